// File: doc/BRIEF.md
# One-Bit Run-to-Halt Sequenced Core

This block is a very small processor whose entire data path is one bit wide. A program of 9-bit instructions sits in an on-block program store. The host writes that store through a simple write port. Each instruction names an operation and one bit of a 64-bit data space. A single accumulator bit carries results from one instruction to the next. There are no jumps, so a program is a straight list of bit operations that ends in a halt.

A start pulse makes the core fetch from location zero and retire one instruction per clock until it decodes a halt. It then returns to idle, raises a one-cycle completion pulse and waits for the next start pulse, which runs the same program again. The top eight data addresses are not storage. A read there returns an external input pin, and a write there sets a held external output pin. Typical uses are small fixed logic functions, bit-level glue and scripted control sequences.

Top module: `obc_core`

## Requirements
- R1: An instruction word has its opcode in bits 8:6 and its data address in bits 5:0. The opcodes are 000 load, 001 load inverted, 010 AND, 011 OR, 100 XOR, 101 store, 110 store inverted and 111 halt.
- R2: Load sets the accumulator to the addressed bit. Load inverted sets it to the complement of that bit.
- R3: AND, OR and XOR replace the accumulator with its logical combination with the addressed bit.
- R4: Store writes the accumulator to the addressed bit, and store inverted writes its complement. The very next instruction reads the new value.
- R5: A start pulse while idle raises busy_o on the following clock edge, and execution begins at program address 0.
- R6: Every instruction takes one clock. With the halt at program address N, busy_o stays high for exactly N+1 cycles.
- R7: When the halt retires, busy_o falls and done_o is high for exactly one cycle, on that same cycle.
- R8: A start pulse that arrives while busy_o is high has no effect on the sequence or on its length.
- R9: A start pulse after a halt runs the program again from address 0, using the current input values.
- R10: Data addresses 56+k (k = 0..7) read ext_in_i[k] and write ext_out_o[k]. An output bit keeps its value until it is written again.
- R11: After reset, busy_o, done_o and all of ext_out_o are 0.
- R12: A word written through the program port at address A is the instruction used at address A on every later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse; only acted on while idle |
| busy_o | output | 1 | High while a program is running |
| done_o | output | 1 | One-cycle pulse when a halt has retired |
| pm_we_i | input | 1 | Program store write enable |
| pm_waddr_i | input | 6 | Program store write address |
| pm_wdata_i | input | 9 | Instruction word to write |
| ext_in_i | input | 8 | External input bits, read at data addresses 56..63 |
| ext_out_o | output | 8 | External output bits, written at data addresses 56..63 |

## Verification
The operation program is run with all four combinations of two input bits. This separates AND, OR and XOR from one another and from the loads, because each operator has its own truth table. A store-then-reload program is run with the source bit at both 0 and 1. That shows internal bits hold values rather than constants, and that a write is visible to the very next instruction. Long programs, programs that halt at once, start pulses sent mid-run and rewritten program words check the run length, the ignored start and the reuse of the program store.

// File: rtl/obc_pkg.sv
package obc_pkg;

  localparam int unsigned OP_W    = 3;
  localparam int unsigned DADDR_W = 6;
  localparam int unsigned INSTR_W = OP_W + DADDR_W;

  typedef enum logic [OP_W-1:0] {
    OP_LD   = 3'b000,
    OP_LDN  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_ST   = 3'b101,
    OP_STN  = 3'b110,
    OP_HALT = 3'b111
  } opcode_e;

  typedef struct packed {
    opcode_e             op;
    logic [DADDR_W-1:0]  addr;
  } instr_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/obc_rst_sync.sv
module obc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/obc_progmem.sv
module obc_progmem #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned WORD_W  = 9
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store_q [DEPTH];
  logic [WORD_W-1:0] rd_data_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      store_q[wr_addr_i] <= wr_data_i;
    end
  end

  // Synchronous read with clock enable; a same-cycle write returns the old word.
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_data_q <= store_q[rd_addr_i];
    end
  end

  assign rd_data_o = rd_data_q;

endmodule

// File: rtl/obc_dataspace.sv
module obc_dataspace #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned EXT_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                rd_bit_o,
  input  logic                wr_en_i,
  input  logic                wr_bit_i,
  input  logic [EXT_BITS-1:0] ext_in_i,
  output logic [EXT_BITS-1:0] ext_out_o
);

  localparam int unsigned SPACE    = 1 << ADDR_W;
  localparam int unsigned RAM_BITS = SPACE - EXT_BITS;
  localparam int unsigned EXT_W    = (EXT_BITS > 1) ? $clog2(EXT_BITS) : 1;
  localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(RAM_BITS);

  logic [RAM_BITS-1:0] ram_q;
  logic [EXT_BITS-1:0] ext_q;
  logic                is_ext;
  logic [ADDR_W-1:0]   ext_off;
  logic [EXT_W-1:0]    ext_idx;
  logic                ram_we;

  always_comb begin
    is_ext  = (addr_i >= EXT_BASE);
    ext_off = addr_i - EXT_BASE;
    ext_idx = ext_off[EXT_W-1:0];
    ram_we  = wr_en_i && !is_ext;
  end

  // Asynchronous read path
  always_comb begin
    if (is_ext) begin
      rd_bit_o = ext_in_i[ext_idx];
    end else begin
      rd_bit_o = ram_q[addr_i];
    end
  end

  // Storage bits: synchronous write, no reset
  always_ff @(posedge clk_i) begin
    if (ram_we) begin
      ram_q[addr_i] <= wr_bit_i;
    end
  end

  // One held output flop per external bit, each with its own enable
  for (genvar g = 0; g < EXT_BITS; g++) begin : g_ext
    logic sel;
    always_comb begin
      sel = wr_en_i && is_ext && (ext_idx == EXT_W'(g));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ext_q[g] <= 1'b0;
      end else if (sel) begin
        ext_q[g] <= wr_bit_i;
      end
    end
  end

  assign ext_out_o = ext_q;

  a_r4_ram_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |=> (ram_q[$past(addr_i)] == $past(wr_bit_i)));

  a_r10_ext_out_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && is_ext) |=> $stable(ext_q));

endmodule

// File: rtl/obc_exec.sv
module obc_exec
  import obc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    exec_en_i,
  input  opcode_e op_i,
  input  logic    dbit_i,
  output logic    st_en_o,
  output logic    st_bit_o,
  output logic    acc_o
);

  logic acc_q;
  logic acc_d;
  logic acc_en;

  // Next-state logic
  always_comb begin
    acc_d    = acc_q;
    acc_en   = 1'b0;
    st_en_o  = 1'b0;
    st_bit_o = acc_q;
    unique case (op_i)
      OP_LD:   begin acc_d = dbit_i;          acc_en = exec_en_i; end
      OP_LDN:  begin acc_d = ~dbit_i;         acc_en = exec_en_i; end
      OP_AND:  begin acc_d = acc_q & dbit_i;  acc_en = exec_en_i; end
      OP_OR:   begin acc_d = acc_q | dbit_i;  acc_en = exec_en_i; end
      OP_XOR:  begin acc_d = acc_q ^ dbit_i;  acc_en = exec_en_i; end
      OP_ST:   begin st_en_o = exec_en_i; st_bit_o = acc_q;  end
      OP_STN:  begin st_en_o = exec_en_i; st_bit_o = ~acc_q; end
      default: begin end
    endcase
  end

  // Register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  a_r2_load_takes_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_i && op_i == OP_LD) |=> (acc_q == $past(dbit_i)));

  a_r4_store_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_i && (op_i == OP_ST || op_i == OP_STN)) |=> $stable(acc_q));

endmodule

// File: rtl/obc_seq.sv
module obc_seq
  import obc_pkg::*;
#(
  parameter int unsigned PA_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  opcode_e         op_i,
  output logic            fetch_en_o,
  output logic [PA_W-1:0] fetch_addr_o,
  output logic            exec_en_o,
  output logic            busy_o,
  output logic            done_o
);

  seq_state_e      state_q, state_d;
  logic [PA_W-1:0] pc_q, pc_d;
  logic            done_q, done_d;
  logic            running;
  logic            launch;
  logic            halting;

  always_comb begin
    running = (state_q == SEQ_RUN);
    launch  = !running && start_i;
    halting = running && (op_i == OP_HALT);
  end

  // Next-state logic
  always_comb begin
    state_d      = state_q;
    pc_d         = pc_q;
    done_d       = 1'b0;
    fetch_en_o   = 1'b0;
    fetch_addr_o = pc_q + 1'b1;
    exec_en_o    = running && !halting;
    if (launch) begin
      state_d      = SEQ_RUN;
      pc_d         = '0;
      fetch_en_o   = 1'b1;
      fetch_addr_o = '0;
    end else if (halting) begin
      state_d = SEQ_IDLE;
      done_d  = 1'b1;
    end else if (running) begin
      pc_d       = pc_q + 1'b1;
      fetch_en_o = 1'b1;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      pc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = running;
  assign done_o = done_q;

  a_r5_start_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && pc_q == '0));

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && op_i != OP_HALT) |=> (busy_o && pc_q == $past(pc_q) + 1'b1));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

// File: rtl/obc_core.sv
module obc_core
  import obc_pkg::*;
#(
  parameter int unsigned PA_W     = 6,
  parameter int unsigned EXT_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                busy_o,
  output logic                done_o,
  input  logic                pm_we_i,
  input  logic [PA_W-1:0]     pm_waddr_i,
  input  logic [INSTR_W-1:0]  pm_wdata_i,
  input  logic [EXT_BITS-1:0] ext_in_i,
  output logic [EXT_BITS-1:0] ext_out_o
);

  logic               rst_n;
  logic               fetch_en;
  logic [PA_W-1:0]    fetch_addr;
  logic [INSTR_W-1:0] ir_word;
  instr_t             ir;
  logic               exec_en;
  logic               dbit;
  logic               st_en;
  logic               st_bit;
  logic               acc;

  always_comb begin
    ir = instr_t'(ir_word);
  end

  obc_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  obc_progmem #(
    .ADDR_W (PA_W),
    .WORD_W (INSTR_W)
  ) u_pm (
    .clk_i     (clk_i),
    .wr_en_i   (pm_we_i),
    .wr_addr_i (pm_waddr_i),
    .wr_data_i (pm_wdata_i),
    .rd_en_i   (fetch_en),
    .rd_addr_i (fetch_addr),
    .rd_data_o (ir_word)
  );

  obc_seq #(
    .PA_W (PA_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .start_i      (start_i),
    .op_i         (ir.op),
    .fetch_en_o   (fetch_en),
    .fetch_addr_o (fetch_addr),
    .exec_en_o    (exec_en),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  obc_dataspace #(
    .ADDR_W   (DADDR_W),
    .EXT_BITS (EXT_BITS)
  ) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .addr_i    (ir.addr),
    .rd_bit_o  (dbit),
    .wr_en_i   (st_en),
    .wr_bit_i  (st_bit),
    .ext_in_i  (ext_in_i),
    .ext_out_o (ext_out_o)
  );

  obc_exec u_exec (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .exec_en_i (exec_en),
    .op_i      (ir.op),
    .dbit_i    (dbit),
    .st_en_o   (st_en),
    .st_bit_o  (st_bit),
    .acc_o     (acc)
  );

  a_r11_idle_after_reset: assert property (@(posedge clk_i)
    !rst_n |=> (!busy_o && !done_o && ext_out_o == '0));

  a_r4_store_only_running: assert property (@(posedge clk_i) disable iff (!rst_n)
    st_en |-> busy_o);

  a_r1_acc_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |=> $stable(acc));

endmodule

// File: tb/obc_core_tb.sv
module obc_core_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic       busy_o;
  logic       done_o;
  logic       pm_we_i;
  logic [5:0] pm_waddr_i;
  logic [8:0] pm_wdata_i;
  logic [7:0] ext_in_i;
  logic [7:0] ext_out_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  int last_busy = 0;

  localparam logic [2:0] LD = 3'b000, LDN = 3'b001, AND_ = 3'b010, OR_ = 3'b011,
                         XOR_ = 3'b100, ST = 3'b101, STN = 3'b110, HLT = 3'b111;

  always #4 clk_i = ~clk_i;

  obc_core u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pm_we_i    (pm_we_i),
    .pm_waddr_i (pm_waddr_i),
    .pm_wdata_i (pm_wdata_i),
    .ext_in_i   (ext_in_i),
    .ext_out_o  (ext_out_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected <150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks = checks + 1;
    if (got != exp) begin
      failures = failures + 1;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [8:0] ins(input logic [2:0] op, input logic [5:0] a);
    return {op, a};
  endfunction

  task automatic pm_write(input int a, input logic [8:0] w);
    pm_we_i    = 1'b1;
    pm_waddr_i = 6'(a);
    pm_wdata_i = w;
    @(negedge clk_i);
    pm_we_i    = 1'b0;
  endtask

  // Runs the program; pulses start mid-run when poke_at >= 0.
  // Checks R5 (busy after start), R7 (done pulse); returns busy length.
  task automatic run_prog(input int poke_at);
    int n;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R5 busy after start", busy_o, 1);
    n = 0;
    while (busy_o && n < 1000) begin
      n = n + 1;
      if (n == poke_at) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    check("R7 done with busy fall", done_o, 1);
    @(negedge clk_i);
    check("R7 done one cycle", done_o, 0);
    last_busy = n;
  endtask

  task automatic t_reset;
    check("R11 busy reset", busy_o, 0);
    check("R11 done reset", done_o, 0);
    check("R11 ext_out reset", ext_out_o, 0);
  endtask

  // R1 R2 R3 R10: operation program over all input pairs; each run is a rerun (R9)
  task automatic t_ops;
    logic [8:0] p [16];
    p[0]  = ins(LD, 56);   p[1]  = ins(ST, 56);
    p[2]  = ins(LDN, 56);  p[3]  = ins(ST, 57);
    p[4]  = ins(LD, 56);   p[5]  = ins(AND_, 57);  p[6]  = ins(ST, 58);
    p[7]  = ins(LD, 56);   p[8]  = ins(OR_, 57);   p[9]  = ins(ST, 59);
    p[10] = ins(LD, 56);   p[11] = ins(XOR_, 57);  p[12] = ins(ST, 60);
    p[13] = ins(LD, 56);   p[14] = ins(STN, 61);   p[15] = ins(HLT, 0);
    for (int i = 0; i < 16; i++) pm_write(i, p[i]);
    for (int v = 0; v < 4; v++) begin
      logic a, b;
      a = v[0]; b = v[1];
      ext_in_i = {6'b0, b, a};
      run_prog(-1);
      check("R6 busy length 16", last_busy, 16);
      check("R2 load", ext_out_o[0], a);
      check("R2 load inverted", ext_out_o[1], !a);
      check("R3 and", ext_out_o[2], a & b);
      check("R3 or", ext_out_o[3], a | b);
      check("R3 xor", ext_out_o[4], a ^ b);
      check("R4 store inverted", ext_out_o[5], !a);
      check("R10 unwritten outputs hold", ext_out_o[7:6], 0);
      check("R9 rerun uses new inputs", ext_out_o[0], a);
    end
  endtask

  // R4: internal store read back by the next instruction
  task automatic t_ram;
    logic [8:0] p [10];
    p[0] = ins(LD, 58);  p[1] = ins(ST, 10);  p[2] = ins(LD, 10);
    p[3] = ins(ST, 62);  p[4] = ins(LD, 58);  p[5] = ins(STN, 11);
    p[6] = ins(LD, 59);  p[7] = ins(LD, 11);  p[8] = ins(ST, 63);
    p[9] = ins(HLT, 0);
    for (int i = 0; i < 10; i++) pm_write(i, p[i]);
    for (int v = 0; v < 2; v++) begin
      ext_in_i = {4'b0, 1'(~v[0]), 1'(v[0]), 2'b0};
      run_prog(-1);
      check("R6 busy length 10", last_busy, 10);
      check("R4 store then reload", ext_out_o[6], v[0]);
      check("R4 store inverted reload", ext_out_o[7], !v[0]);
    end
  endtask

  // R8: start during a long run is ignored
  task automatic t_ignore;
    for (int i = 0; i < 40; i++) pm_write(i, ins(LD, 56));
    pm_write(40, ins(HLT, 0));
    run_prog(5);
    check("R8 start ignored length", last_busy, 41);
    check("R8 idle after", busy_o, 0);
  endtask

  // R12 and immediate halt
  task automatic t_reload;
    ext_in_i = 8'h01;
    pm_write(0, ins(LD, 56));
    pm_write(1, ins(ST, 56));
    pm_write(2, ins(HLT, 0));
    run_prog(-1);
    check("R12 first program", ext_out_o[0], 1);
    pm_write(1, ins(STN, 56));
    run_prog(-1);
    check("R12 rewritten word used", ext_out_o[0], 0);
    pm_write(0, ins(HLT, 0));
    run_prog(-1);
    check("R6 halt at 0 length 1", last_busy, 1);
    check("R12 halt at 0 leaves outputs", ext_out_o[0], 0);
  endtask

  initial begin
    rst_ni     = 1'b0;
    start_i    = 1'b0;
    pm_we_i    = 1'b0;
    pm_waddr_i = '0;
    pm_wdata_i = '0;
    ext_in_i   = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_ops();
    t_ram();
    t_ignore();
    t_reload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule